// File: doc/BRIEF.md
# Memory-Scanning Running-Sum Engine

This block steps through a byte-wide memory from address zero upward, one location per step. It adds each byte it reads into a running total and keeps that total modulo 2^DATA_W. When a location reads as all zeros, the block writes the current total back to that same address. A caller preloads the memory with a list of values followed by an empty slot. After the scan has passed that slot, the slot holds the sum of the list.

The memory sits outside the block and has a synchronous read with one cycle of latency. A control sequencer spreads each step over two clock cycles. In the first cycle the new address is presented. In the second cycle the read data is valid, and the block updates the total and may strobe a write. The address is always stable while the strobe is high.

The address counter runs freely and wraps from its all-ones value back to zero. After a wrap the total carries on from where it stood. A synchronous clear returns the counter, the total and the sequencer to their reset values and holds the scan stopped for as long as it is asserted.

Sequencer states:
- `SEQ_HALT`: held here while clear is asserted, and entered from reset.
- `SEQ_FETCH`: the address is on the bus and the memory read is in flight.
- `SEQ_PULSE`: the read data is valid, the total updates and a write may occur.

Sequencer transitions:
- `HALT->FETCH` when clear is low.
- `FETCH->PULSE` always.
- `PULSE->FETCH` always, and the address advances on the same edge.
- Any state goes to `HALT` while clear is high.

Top module: `scan_sum_engine`

## Requirements
- R1: After reset (`rst_n` low), `addr` is 0, `wr_data` (the running total) is 0 and `wr_en` is 0.
- R2: While `clear` is high, the scan is stopped: `addr` stays 0, `wr_data` stays 0 and `wr_en` stays 0, starting from the first edge that samples `clear` high.
- R3: Each step lasts two cycles. `addr` holds its value through the fetch cycle and the pulse cycle, then advances by exactly one on the edge that ends the pulse cycle.
- R4: On the edge that ends a pulse cycle, the total becomes (total + `rd_data`) mod 2^DATA_W. The carry is discarded, and `wr_data` shows the total at all times.
- R5: Because the total starts at 0, the first step after reset or clear leaves a total equal to the first byte read.
- R6: In the pulse cycle, when `rd_data` is all zeros, `wr_en` is 1 for that single cycle. `addr` is the location just read and `wr_data` is the current total, which that step does not change.
- R7: A step that reads a nonzero byte raises no write strobe, and that memory location keeps its value.
- R8: After the step at address 2^ADDR_W-1, `addr` wraps to 0 and accumulation continues on top of the existing total.
- R9: With 35h, 1Bh, 09h, 31h, 1Eh, 12h, 23h, 0Ch at addresses 0 to 7 and 00h at address 8, the scan writes E9h to address 8.
- R10: `wr_en` is never high on two consecutive cycles, and it is high only when `addr` equals its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear and hold of the scan |
| rd_data | input | DATA_W | Read data from memory, one cycle after `addr` |
| addr | output | ADDR_W | Memory address |
| wr_data | output | DATA_W | Running total, also the write data |
| wr_en | output | 1 | Memory write strobe |

## Verification
The bench builds the block with ADDR_W=6 and DATA_W=8. The 64-word address space lets one full pass and the wrap back to address 0 complete in a few hundred cycles. Because the data width is kept at a byte, the second pass over the example list carries past FFh, so the modulo behaviour of the total is visible at the ports. The run starts with the example list, which fills every empty slot with E9h. It then checks the wrapped total of 1Eh. Finally it asserts clear mid-scan and confirms that the first byte passes through unchanged on restart.

// File: rtl/scan_sum_pkg.sv
package scan_sum_pkg;

    typedef enum logic [1:0] {
        SEQ_HALT  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_PULSE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import scan_sum_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    output seq_state_e state,
    output logic       pulse
);

    seq_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        if (clear) begin
            state_nxt = SEQ_HALT;
        end else begin
            unique case (state)
                SEQ_HALT:  state_nxt = SEQ_FETCH;
                SEQ_FETCH: state_nxt = SEQ_PULSE;
                SEQ_PULSE: state_nxt = SEQ_FETCH;
                default:   state_nxt = SEQ_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_HALT;
        else        state <= state_nxt;
    end

    // output decode: strobe only in the second phase of a step
    always_comb begin
        pulse = 1'b0;
        unique case (state)
            SEQ_HALT:  pulse = 1'b0;
            SEQ_FETCH: pulse = 1'b0;
            SEQ_PULSE: pulse = 1'b1;
            default:   pulse = 1'b0;
        endcase
    end

    // R10: the strobe phase never repeats back to back
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (clear) addr <= '0;
        else if (step)  addr <= addr + ADDR_ONE;
    end

endmodule

// File: rtl/scan_accum.sv
module scan_accum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] total,
    output logic              is_zero
);

    logic [DATA_W-1:0] sum;

    // carry out of the top bit is dropped: modulo 2^DATA_W
    assign sum     = total + rd_data;
    assign is_zero = ~|rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     total <= '0;
        else if (clear) total <= '0;
        else if (load)  total <= sum;
    end

    // R4: the total moves only on a load strobe
    p_total_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || clear)
        !load |=> $stable(total));

endmodule

// File: rtl/scan_sum_engine.sv
module scan_sum_engine
    import scan_sum_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    seq_state_e state;
    logic       pulse;
    logic       is_zero;

    scan_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .state (state),
        .pulse (pulse)
    );

    scan_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (pulse),
        .addr  (addr)
    );

    scan_accum #(.DATA_W(DATA_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load    (pulse),
        .rd_data (rd_data),
        .total   (wr_data),
        .is_zero (is_zero)
    );

    assign wr_en = pulse & is_zero;

    // R2: clear stops the scan and zeroes address and total
    p_clear_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (addr == '0 && wr_data == '0 && !wr_en));

    // R3: address is held across the fetch phase
    p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (state == SEQ_FETCH) |=> $stable(addr));

    // R3: address advances by one after the strobe phase
    p_pulse_adv_r3: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (state == SEQ_PULSE) |=> (addr == $past(addr) + ADDR_ONE));

    // R6: writing on a zero byte leaves the total unchanged
    p_zero_keep_r6: assert property (@(posedge clk) disable iff (!rst_n || clear)
        wr_en |=> $stable(wr_data));

    // R10: a write strobe only sees an address that has settled
    p_wr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n || clear)
        wr_en |-> $stable(addr));

endmodule

// File: tb/test_scan_sum_engine.sv
module test_scan_sum_engine;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    localparam logic [7:0] STEP_BYTE [0:8] =
        '{8'h35, 8'h1B, 8'h09, 8'h31, 8'h1E, 8'h12, 8'h23, 8'h0C, 8'h00};
    localparam logic [7:0] STEP_SUM  [0:8] =
        '{8'h35, 8'h50, 8'h59, 8'h8A, 8'hA8, 8'hBA, 8'hDD, 8'hE9, 8'hE9};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic [DW-1:0] rd_q;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic          wr_en;
    logic [DW-1:0] mem [0:DEPTH-1];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scan_sum_engine #(.ADDR_W(AW), .DATA_W(DW)) i_scan_sum_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .rd_data (rd_q),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en)
    );

    // synchronous memory, one cycle read latency, read-before-write
    always @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
        rd_q <= mem[addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
        for (int k = 0; k < 8; k++) mem[k] = STEP_BYTE[k];
        rd_q = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(addr == 0, "R1 addr", int'(addr), 0);
        chk(wr_data == 0, "R1 total", int'(wr_data), 0);
        chk(wr_en == 0, "R1 wr_en", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk); // fetch of address 0
        chk(addr == 0, "R3 start addr", int'(addr), 0);

        // table walk: R9 example list, R4/R5 totals, R6/R7 strobes
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); // pulse cycle
            chk(addr == AW'(i), "R3 addr held", int'(addr), i);
            chk(wr_en == (STEP_BYTE[i] == 8'h00), "R6 R7 strobe", int'(wr_en),
                int'(STEP_BYTE[i] == 8'h00));
            @(negedge clk); // next fetch
            chk(wr_data == STEP_SUM[i], (i == 0) ? "R5 first byte" : "R4 total",
                int'(wr_data), int'(STEP_SUM[i]));
            chk(addr == AW'(i + 1), "R3 advance", int'(addr), i + 1);
        end
        chk(mem[8] == 8'hE9, "R9 sum written", int'(mem[8]), 'hE9);
        chk(mem[3] == 8'h31, "R7 nonzero kept", int'(mem[3]), 'h31);

        // remaining empty slots up to the wrap
        for (int i = 9; i < DEPTH; i++) begin
            @(negedge clk);
            chk(wr_en == 1'b1, "R6 zero write", int'(wr_en), 1);
            @(negedge clk);
            chk(wr_data == 8'hE9, "R6 total kept", int'(wr_data), 'hE9);
        end
        chk(addr == 0, "R8 wrap", int'(addr), 0);
        chk(mem[DEPTH-1] == 8'hE9, "R6 last slot", int'(mem[DEPTH-1]), 'hE9);

        // second pass: E9h + 35h = 11Eh -> 1Eh
        @(negedge clk);
        chk(wr_en == 1'b0, "R7 no write", int'(wr_en), 0);
        @(negedge clk);
        chk(wr_data == 8'h1E, "R8 R4 modulo carry", int'(wr_data), 'h1E);
        chk(addr == 1, "R8 continue", int'(addr), 1);

        // clear mid-scan
        clear = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(addr == 0, "R2 addr", int'(addr), 0);
            chk(wr_data == 0, "R2 total", int'(wr_data), 0);
            chk(wr_en == 0, "R2 wr_en", int'(wr_en), 0);
        end
        clear = 1'b0;
        @(negedge clk); // fetch of address 0
        chk(addr == 0, "R1 restart addr", int'(addr), 0);
        @(negedge clk); // pulse
        @(negedge clk);
        chk(wr_data == 8'h35, "R5 after clear", int'(wr_data), 'h35);
        chk(addr == 1, "R3 after clear", int'(addr), 1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule